// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block converts single read and write requests from an internal master into timed strobe sequences for external asynchronous SRAM, ROM or NOR parts. Four banks share the external address, data and strobe lines. Each bank has its own active-low chip select. The top two bits of the request address choose the bank, and the remaining bits address the device.

Every bank holds two timing sets: one applies to reads and the other to writes. Each 16-bit set has four 4-bit fields:

- bits [3:0]: address setup
- bits [7:4]: data-phase wait states
- bits [11:8]: strobe delay
- bits [15:12]: bus turnaround

A per-bank width bit selects an 8-bit or a 16-bit device. The master raises `reqValid` with the address, write data and size. It holds them until `rspReady` pulses, and read data is returned with that pulse.

A strobe is `memOeN` for reads and `memWeN` for writes. An access runs through these phases:

1. Address setup.
2. Strobe delay. In these first two phases the chip select is low but the strobe is not.
3. Data phase, with the strobe low.
4. Completion cycle.
5. Turnaround gap, during which no new request is taken.

Top module: `asyncMemCtrl`

## Requirements
- R1: While reset is held, all four chip selects, `memOeN` and `memWeN` are high, `memDataOe` is low and `rspReady` is low.
- R2: The bank is decoded from the top two address bits. Only that bank's chip select goes low, and at most one chip select is low at any time. The chip select stays low for the whole access.
- R3: Before the strobe goes low, the chip select is low for exactly setup + strobe-delay cycles. Setup is field [3:0] and strobe delay is field [11:8] of the selected timing set.
- R4: The strobe stays low for exactly wait + 1 cycles, where wait is field [7:4] of the selected timing set.
- R5: Reads use the bank's read timing set from `cfgRdTiming`, and writes use its write set from `cfgWrTiming`. In both vectors, bank n occupies bits [16n+15:16n].
- R6: `memOeN` and `memWeN` are never low together. During a write `memOeN` stays high, and during a read `memWeN` stays high. `memDataOe` is high exactly in the cycles where `memWeN` is low.
- R7: Read data is taken from `memDataIn` at the clock edge that ends the last strobe-low cycle.
- R8: `rspReady` is high for exactly one cycle, the cycle after the strobe rises, and all chip selects are high in that cycle. For a read, `rspData` holds the read result in that cycle.
- R9: After a completed access with turnaround T (field [15:12] of that access's timing set), all chip selects stay high for at least T+1 cycles. A request held waiting is started after exactly T+1 such cycles.
- R10: On a 16-bit bank (`cfgWide` bit = 1):
  - `memAddr` is the offset shifted right by one.
  - A halfword access (`reqHalf` = 1) has `memByteN` = 00 and transfers all 16 bits.
  - A byte access enables lane 1 (`memByteN` = 01) when offset bit 0 is 1, and lane 0 (`memByteN` = 10) otherwise.
  - Byte writes replicate `reqWdata[7:0]` on both lanes. Byte reads return the selected byte, zero-extended.
- R11: On an 8-bit bank (`cfgWide` bit = 0):
  - `memAddr` is the full offset and `memByteN` = 10.
  - Writes place `reqWdata[7:0]` on both bytes.
  - Reads return `memDataIn[7:0]`, zero-extended, whatever the value of `reqHalf`.
- R12: `memAddr` and `memByteN` stay stable while a strobe is low. `memByteN` is 11 whenever no chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until rspReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqHalf | input | 1 | 1 = 16-bit transfer, 0 = byte |
| reqAddr | input | ADDR_W | Top two bits bank, rest byte offset |
| reqWdata | input | 16 | Write data |
| rspReady | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read result |
| cfgRdTiming | input | 64 | Read timing sets, 16 bits per bank |
| cfgWrTiming | input | 64 | Write timing sets, 16 bits per bank |
| cfgWide | input | 4 | Per-bank device width, 1 = 16 bits |
| memCsN | output | 4 | Active-low chip selects |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | ADDR_W-2 | Device address |
| memByteN | output | 2 | Active-low byte lane enables |
| memDataOut | output | 16 | Write data to the pads |
| memDataOe | output | 1 | Pad output enable for memDataOut |
| memDataIn | input | 16 | Read data from the pads |

## Verification
The bench builds the controller with a 10-bit request address, which leaves an 8-bit device offset. This keeps the address patterns readable and lets every offset bit, including the byte-lane bit, be steered directly. It sets banks 0 and 2 to 16-bit width and banks 1 and 3 to 8-bit width, so both data paths are covered. Timing fields range from all zero to all fifteen. This covers a one-cycle strobe with no setup as well as the longest setup, strobe and turnaround windows. Chained requests test the turnaround gap at both its smallest and a non-zero value.

// File: rtl/amcPkg.sv
package amcPkg;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] turn;
    logic [CNT_W-1:0] strobeDly;
    logic [CNT_W-1:0] dataWait;
    logic [CNT_W-1:0] addrSetup;
  } timing_t;

  localparam int TIM_W = $bits(timing_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DELAY, ST_DATA, ST_TURN
  } phase_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic busActive;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/amcCtrl.sv
module amcCtrl
  import amcPkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [BANK_BITS-1:0]       reqBank,
  input  logic [NUM_BANKS*TIM_W-1:0] cfgRd,
  input  logic [NUM_BANKS*TIM_W-1:0] cfgWr,
  output logic [NUM_BANKS-1:0]       csN,
  output logic                       oeN,
  output logic                       weN,
  output logic                       rspReady,
  output strobe_t                    strb
);
  timing_t rdSet [NUM_BANKS];
  timing_t wrSet [NUM_BANKS];
  timing_t selTim, timReg;
  phase_e state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [BANK_BITS-1:0] bankReg;
  logic wrReg, accept, finish, busy, readyQ;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_unpack
    assign rdSet[i] = cfgRd[i*TIM_W +: TIM_W];
    assign wrSet[i] = cfgWr[i*TIM_W +: TIM_W];
  end

  assign selTim = reqWrite ? wrSet[reqBank] : rdSet[reqBank];

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    accept   = 1'b0;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        accept = 1'b1;
        if (selTim.addrSetup != '0) begin
          stateNxt = ST_SETUP; cntNxt = selTim.addrSetup - 1'b1;
        end else if (selTim.strobeDly != '0) begin
          stateNxt = ST_DELAY; cntNxt = selTim.strobeDly - 1'b1;
        end else begin
          stateNxt = ST_DATA;  cntNxt = selTim.dataWait;
        end
      end
      ST_SETUP: if (cnt != '0) cntNxt = cnt - 1'b1;
        else if (timReg.strobeDly != '0) begin
          stateNxt = ST_DELAY; cntNxt = timReg.strobeDly - 1'b1;
        end else begin
          stateNxt = ST_DATA;  cntNxt = timReg.dataWait;
        end
      ST_DELAY: if (cnt != '0) cntNxt = cnt - 1'b1;
        else begin
          stateNxt = ST_DATA; cntNxt = timReg.dataWait;
        end
      ST_DATA: if (cnt != '0) cntNxt = cnt - 1'b1;
        else begin
          finish = 1'b1;
          if (timReg.turn != '0) begin
            stateNxt = ST_TURN; cntNxt = timReg.turn - 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      ST_TURN: if (cnt != '0) cntNxt = cnt - 1'b1;
        else stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      timReg  <= '0;
      bankReg <= '0;
      wrReg   <= 1'b0;
      readyQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      readyQ <= finish;
      if (accept) begin
        timReg  <= selTim;
        bankReg <= reqBank;
        wrReg   <= reqWrite;
      end
    end
  end

  assign busy = (state == ST_SETUP) || (state == ST_DELAY) || (state == ST_DATA);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cs
    assign csN[i] = ~(busy && (bankReg == BANK_BITS'(i)));
  end

  assign oeN      = ~((state == ST_DATA) && !wrReg);
  assign weN      = ~((state == ST_DATA) && wrReg);
  assign rspReady = readyQ;

  assign strb.load      = accept;
  assign strb.capture   = finish && !wrReg;
  assign strb.busActive = busy;
  assign strb.drive     = (state == ST_DATA) && wrReg;

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);
  // R8
  ready_cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (&csN && oeN && weN));
endmodule

// File: rtl/amcDatapath.sv
module amcDatapath
  import amcPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int OFF_W = ADDR_W - BANK_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               reqHalf,
  input  logic [NUM_BANKS-1:0] cfgWide,
  input  logic [DATA_W-1:0]  memDataIn,
  output logic [OFF_W-1:0]   memAddr,
  output logic [1:0]         memByteN,
  output logic [DATA_W-1:0]  memDataOut,
  output logic               memDataOe,
  output logic [DATA_W-1:0]  rspData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdQ, rdSel;
  logic halfQ, wide, fullWord;
  logic [OFF_W-1:0] off;
  logic [1:0] lanes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      halfQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        halfQ  <= reqHalf;
      end
      if (strb.capture) rdQ <= rdSel;
    end
  end

  assign wide     = cfgWide[addrQ[ADDR_W-1 -: BANK_BITS]];
  assign off      = addrQ[OFF_W-1:0];
  assign fullWord = wide && halfQ;

  assign memAddr = wide ? {1'b0, off[OFF_W-1:1]} : off;

  always_comb begin
    if (!wide)         lanes = 2'b10;
    else if (halfQ)    lanes = 2'b00;
    else if (off[0])   lanes = 2'b01;
    else               lanes = 2'b10;
  end

  always_comb begin
    if (fullWord)            rdSel = memDataIn;
    else if (wide && off[0]) rdSel = {8'h00, memDataIn[15:8]};
    else                     rdSel = {8'h00, memDataIn[7:0]};
  end

  assign memByteN   = strb.busActive ? lanes : 2'b11;
  assign memDataOut = fullWord ? wdataQ : {wdataQ[7:0], wdataQ[7:0]};
  assign memDataOe  = strb.drive;
  assign rspData    = rdQ;
endmodule

// File: rtl/asyncMemCtrl.sv
module asyncMemCtrl
  import amcPkg::*;
#(
  parameter int ADDR_W = 22,
  localparam int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int OFF_W = ADDR_W - BANK_BITS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic                       reqHalf,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          reqWdata,
  output logic                       rspReady,
  output logic [DATA_W-1:0]          rspData,
  input  logic [NUM_BANKS*TIM_W-1:0] cfgRdTiming,
  input  logic [NUM_BANKS*TIM_W-1:0] cfgWrTiming,
  input  logic [NUM_BANKS-1:0]       cfgWide,
  output logic [NUM_BANKS-1:0]       memCsN,
  output logic                       memOeN,
  output logic                       memWeN,
  output logic [OFF_W-1:0]           memAddr,
  output logic [1:0]                 memByteN,
  output logic [DATA_W-1:0]          memDataOut,
  output logic                       memDataOe,
  input  logic [DATA_W-1:0]          memDataIn
);
  strobe_t strb;

  amcCtrl #(.BANK_BITS(BANK_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqAddr[ADDR_W-1 -: BANK_BITS]),
    .cfgRd(cfgRdTiming), .cfgWr(cfgWrTiming),
    .csN(memCsN), .oeN(memOeN), .weN(memWeN),
    .rspReady(rspReady), .strb(strb)
  );

  amcDatapath #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqHalf(reqHalf), .cfgWide(cfgWide),
    .memDataIn(memDataIn), .memAddr(memAddr), .memByteN(memByteN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .rspData(rspData)
  );

  // R6
  drive_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> !memWeN);
  // R12
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!memOeN || !memWeN) && $past(!memOeN || !memWeN)) |-> $stable(memAddr));
  // R12
  lanes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&memCsN) |-> (memByteN == 2'b11));
endmodule

// File: tb/test_asyncMemCtrl.sv
`timescale 1ns/1ps
module test_asyncMemCtrl;
  localparam int ADDR_W = 10;
  localparam int OFF_W  = ADDR_W - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqHalf = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic rspReady;
  logic [15:0] rspData;
  logic [15:0] rdT [4];
  logic [15:0] wrT [4];
  logic [3:0] wideV = 4'b0101;
  logic [3:0] memCsN;
  logic memOeN, memWeN, memDataOe;
  logic [OFF_W-1:0] memAddr;
  logic [1:0] memByteN;
  logic [15:0] memDataOut, memDataIn;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] model(input logic [OFF_W-1:0] x);
    return {x[7:0] ^ 8'h3C, x[7:0] + 8'h11};
  endfunction

  assign memDataIn = !memOeN ? model(memAddr) : 16'hDEAD;

  asyncMemCtrl #(.ADDR_W(ADDR_W)) i_asyncMemCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqHalf(reqHalf), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspReady(rspReady), .rspData(rspData),
    .cfgRdTiming({rdT[3], rdT[2], rdT[1], rdT[0]}),
    .cfgWrTiming({wrT[3], wrT[2], wrT[1], wrT[0]}),
    .cfgWide(wideV), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memByteN(memByteN), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Starts at a negedge. chained: the previous request's ready was seen this
  // negedge and expIdle cycles with no chip select are expected first.
  task automatic doAccess(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [15:0] wd, input bit half,
                          input bit chained, input int expIdle,
                          input bit hold, input string tag);
    logic [1:0] bank = a[ADDR_W-1 -: 2];
    logic [15:0] t = wr ? wrT[bank] : rdT[bank];
    bit wide = wideV[bank];
    logic [OFF_W-1:0] off = a[OFF_W-1:0];
    logic [OFF_W-1:0] expAddr = wide ? (off >> 1) : off;
    logic [1:0] expLanes = !wide ? 2'b10 : half ? 2'b00 : (off[0] ? 2'b01 : 2'b10);
    logic [15:0] expOut = (wide && half) ? wd : {wd[7:0], wd[7:0]};
    logic [15:0] w = model(expAddr);
    logic [15:0] expRd = (wide && half) ? w : (wide && off[0]) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    int idle = 0, pre = 0, stb = 0, wrongCs = 0, otherBad = 0, driveBad = 0;
    int addrBad = 0, dataBad = 0, postBad = 0;
    bit got = 0;
    if (!chained) begin
      repeat (18) @(negedge clk);
      expIdle = 0;
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqHalf = half;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (rspReady) begin got = 1; break; end
      begin
        logic [3:0] cs = ~memCsN;
        bit act = wr ? !memWeN : !memOeN;
        bit oth = wr ? !memOeN : !memWeN;
        if (cs == 0) begin
          if (stb > 0 || pre > 0) postBad++; else idle++;
          if (act) otherBad++;
        end else begin
          if (cs != (4'b1 << bank)) wrongCs++;
          if (act) stb++;
          else if (stb > 0) postBad++;
          else pre++;
          if (memAddr != expAddr || memByteN != expLanes) addrBad++;
        end
        if (oth) otherBad++;
        if (memDataOe !== (wr && act)) driveBad++;
        if (wr && act && memDataOut != expOut) dataBad++;
      end
    end
    check(got, {tag, " R8 ready seen"}, got, 1);
    check(idle == expIdle, {tag, " R9 idle before access"}, idle, expIdle);
    check(pre == t[3:0] + t[11:8], {tag, " R3/R5 setup+delay"}, pre, t[3:0] + t[11:8]);
    check(stb == t[7:4] + 1, {tag, " R4/R5 strobe width"}, stb, t[7:4] + 1);
    check(wrongCs == 0 && postBad == 0, {tag, " R2 chip select"}, wrongCs + postBad, 0);
    check(otherBad == 0 && driveBad == 0, {tag, " R6 strobe/drive"}, otherBad + driveBad, 0);
    check(addrBad == 0, {tag, wide ? " R10" : " R11", " address/lanes"}, addrBad, 0);
    if (wr) check(dataBad == 0, {tag, wide ? " R10" : " R11", " write data"}, dataBad, 0);
    else check(rspData == expRd, {tag, " R7 read data"}, rspData, expRd);
    check(memCsN == 4'hF && memByteN == 2'b11, {tag, " R8/R12 idle at ready"}, {memCsN, memByteN}, 6'h3F);
    if (!hold) begin
      reqValid = 1'b0;
      @(negedge clk);
      check(!rspReady, {tag, " R8 single pulse"}, rspReady, 0);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(memCsN == 4'hF && memOeN && memWeN, "R1 strobes idle", {memCsN, memOeN, memWeN}, 6'h3F);
    check(!memDataOe && !rspReady, "R1 no drive/ready", {memDataOe, rspReady}, 0);
    rstN = 1'b1;
  endtask

  task automatic testBankReads();
    rdT[0] = 16'h0120; rdT[1] = 16'h0312; rdT[2] = 16'h1031; rdT[3] = 16'h0203;
    for (int b = 0; b < 4; b++) begin
      doAccess(0, {b[1:0], 8'h5A}, 16'h0, 1, 0, 0, 0, "reads half");
      doAccess(0, {b[1:0], 8'hA7}, 16'h0, 0, 0, 0, 0, "reads byte");
    end
  endtask

  task automatic testWrites();
    wrT[0] = 16'h0211; wrT[1] = 16'h0030; wrT[2] = 16'h1102; wrT[3] = 16'h0420;
    for (int b = 0; b < 4; b++) begin
      doAccess(1, {b[1:0], 8'h3C}, 16'hBEEF, 1, 0, 0, 0, "writes half");
      doAccess(1, {b[1:0], 8'hC3}, 16'h1234, 0, 0, 0, 0, "writes byte");
    end
  endtask

  task automatic testSeparateSets();
    rdT[1] = 16'h0231; wrT[1] = 16'h0905;
    doAccess(0, 10'h111, 16'h0, 0, 0, 0, 0, "R5 read set");
    doAccess(1, 10'h111, 16'h00AB, 0, 0, 0, 0, "R5 write set");
  endtask

  task automatic testTurnaround();
    wrT[2] = 16'h3101; rdT[3] = 16'h0010; rdT[0] = 16'h0000;
    doAccess(1, 10'h204, 16'hCAFE, 1, 0, 0, 1, "R9 first");
    doAccess(0, 10'h309, 16'h0, 0, 1, 3, 1, "R9 after turn 3");
    doAccess(0, 10'h006, 16'h0, 1, 1, 0, 0, "R9 after turn 0");
  endtask

  task automatic testExtremes();
    rdT[2] = 16'h0000; wrT[0] = 16'hFFFF; rdT[1] = 16'hFFFF;
    doAccess(0, 10'h2FF, 16'h0, 1, 0, 0, 0, "zero timing");
    doAccess(1, 10'h0FE, 16'h55AA, 1, 0, 0, 1, "max timing write");
    doAccess(0, 10'h1FF, 16'h0, 1, 1, 15, 0, "max turn then read");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin rdT[i] = '0; wrT[i] = '0; end
    testReset();
    testBankReads();
    testWrites();
    testSeparateSets();
    testTurnaround();
    testExtremes();
    repeat (5) @(negedge clk);
    finishRun();
  end

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule